// File: doc/BRIEF.md
# Multi-Mode Prescaled Compare Timer

This block is a general-purpose timer core. A programmable prescaler divides the system clock, and each prescaler period advances a wide up-counter by one. The counter is compared against a programmable target. When the counter reaches the target, a sticky match flag is raised. What happens next depends on the selected mode: the timer stops (one-shot), restarts from zero (periodic), restarts from zero and inverts an output pin (toggle), or keeps counting (continuous).

Software reaches the timer through a small word-addressed register port with four locations:

- a control word,
- the compare target,
- a flag word with write-one-to-clear bits,
- a counter snapshot.

The match flag drives an interrupt line through an enable. The interrupt can also raise a wake-up request, which is latched into its own flag. A debug-halt input can freeze counting unless software has asked for the timer to ignore it.

Top module: `pscmp_timer`

## Requirements
- R1: While enabled and not halted, the counter advances by one exactly once every PRESCALE+1 clock cycles, where PRESCALE is control bits [7:0].
- R2: Register addresses are 0 control, 1 compare target, 2 flags, 3 counter snapshot. After reset every register reads 0 and irq, wake and tgl_out are 0.
- R3: An advance that makes the new counter value equal the compare target sets the match flag (flags bit 0). Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R4: The mode is set by control bits [9:8]. With mode 0 (one-shot), a match returns the counter to 0 and clears the enable bit (control bit 10).
- R5: With mode 1 (periodic) or mode 2 (toggle), a match returns the counter to 0 and counting continues. In mode 2, tgl_out inverts on every match.
- R6: With mode 3 (continuous), a match leaves the counter incrementing, and the counter wraps from its maximum to 0.
- R7: irq is high exactly while the match flag is 1 and interrupt enable (control bit 11) is 1.
- R8: wake is high while the match flag, interrupt enable and wake enable (control bit 12) are all 1. The cycle after wake is high, the wake flag (flags bit 1) is set. Writing 1 to flags bit 1 clears the wake flag.
- R9: A write to the compare target restarts the counter and the prescaler from 0 in modes 0 to 2. In mode 3, the same write leaves the count running.
- R10: A control write with the clear bit (control bit 15) set zeroes the prescaler and the counter, and forces enable to 0 if it was 1. If enable was 0, the written enable value is taken. The clear bit always reads 0.
- R11: Control bit 16 is read-only and reads 1 while the counter is running (enabled).
- R12: With control bit 14 at 0, counting pauses while dbg_halt is high. With bit 14 at 1, dbg_halt has no effect.
- R13: With control bit 13 at 1, the snapshot at address 3 takes the counter value every cycle, one cycle behind the counter. With bit 13 at 0, the snapshot holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| dbg_halt | input | 1 | Debug halt request |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |
| tgl_out | output | 1 | Toggle-mode output pin |

## Verification
The assertions assume that the register port carries at most one write per cycle, and that reg_addr is valid whenever reg_wr is high. Under these assumptions, the writes that restart or clear the counter are the only reasons the counter may leave its mode-defined path.

The stimulus drives every input half a cycle away from the clock edge. It issues writes one at a time through a task. Random prescale and target values are kept within small ranges, so that several full match periods fit into each run.

// File: rtl/pscmp_timer.sv
module pscmp_timer #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 24,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          dbg_halt,
  output logic          irq,
  output logic          wake,
  output logic          tgl_out
);

  localparam int B_MODE = PSC_W;
  localparam int B_EN   = PSC_W + 2;
  localparam int B_IEN  = PSC_W + 3;
  localparam int B_WEN  = PSC_W + 4;
  localparam int B_VIEW = PSC_W + 5;
  localparam int B_DBG  = PSC_W + 6;
  localparam int B_CLR  = PSC_W + 7;
  localparam int B_ACT  = PSC_W + 8;

  localparam logic [1:0] M_ONE  = 2'd0;
  localparam logic [1:0] M_TGL  = 2'd2;
  localparam logic [1:0] M_CONT = 2'd3;

  logic [PSC_W-1:0] psc_q, pcnt_q;
  logic [1:0]       mode_q;
  logic             en_q, ien_q, wen_q, view_q, dbgrun_q;
  logic [CNT_W-1:0] cmp_q, cnt_q, snap_q, cnt_inc;
  logic             mflag_q, wflag_q, tgl_q;

  logic wr_ctrl, wr_cmp, wr_flg, clr_req, restart, run, tick, hit, wake_lvl;
  logic unused_wbits;

  assign wr_ctrl = reg_wr && (reg_addr == 2'd0);
  assign wr_cmp  = reg_wr && (reg_addr == 2'd1);
  assign wr_flg  = reg_wr && (reg_addr == 2'd2);
  assign clr_req = wr_ctrl && reg_wdata[B_CLR];
  assign restart = clr_req || (wr_cmp && mode_q != M_CONT);

  assign run     = en_q && (dbgrun_q || !dbg_halt);
  assign tick    = run && (pcnt_q == psc_q);
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign hit     = tick && (cnt_inc == cmp_q);

  assign wake_lvl = mflag_q && ien_q && wen_q;
  assign irq      = mflag_q && ien_q;
  assign wake     = wake_lvl;
  assign tgl_out  = tgl_q;
  assign unused_wbits = ^reg_wdata[DW-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q    <= '0;
      mode_q   <= M_ONE;
      en_q     <= 1'b0;
      ien_q    <= 1'b0;
      wen_q    <= 1'b0;
      view_q   <= 1'b0;
      dbgrun_q <= 1'b0;
    end else if (wr_ctrl) begin
      psc_q    <= reg_wdata[PSC_W-1:0];
      mode_q   <= reg_wdata[B_MODE +: 2];
      en_q     <= (clr_req && en_q) ? 1'b0 : reg_wdata[B_EN];
      ien_q    <= reg_wdata[B_IEN];
      wen_q    <= reg_wdata[B_WEN];
      view_q   <= reg_wdata[B_VIEW];
      dbgrun_q <= reg_wdata[B_DBG];
    end else if (hit && mode_q == M_ONE) begin
      en_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else if (wr_cmp) cmp_q <= reg_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
    end else if (restart) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
    end else if (run) begin
      pcnt_q <= tick ? '0 : pcnt_q + PSC_W'(1);
      if (tick) cnt_q <= (hit && mode_q != M_CONT) ? '0 : cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mflag_q <= 1'b0;
      wflag_q <= 1'b0;
      tgl_q   <= 1'b0;
      snap_q  <= '0;
    end else begin
      if (hit) mflag_q <= 1'b1;
      else if (wr_flg && reg_wdata[0]) mflag_q <= 1'b0;
      if (wake_lvl) wflag_q <= 1'b1;
      else if (wr_flg && reg_wdata[1]) wflag_q <= 1'b0;
      if (hit && mode_q == M_TGL) tgl_q <= ~tgl_q;
      if (view_q) snap_q <= cnt_q;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[PSC_W-1:0]   = psc_q;
        reg_rdata[B_MODE +: 2] = mode_q;
        reg_rdata[B_EN]        = en_q;
        reg_rdata[B_IEN]       = ien_q;
        reg_rdata[B_WEN]       = wen_q;
        reg_rdata[B_VIEW]      = view_q;
        reg_rdata[B_DBG]       = dbgrun_q;
        reg_rdata[B_ACT]       = en_q;
      end
      2'd1: reg_rdata[CNT_W-1:0] = cmp_q;
      2'd2: reg_rdata[1:0] = {wflag_q, mflag_q};
      default: reg_rdata[CNT_W-1:0] = snap_q;
    endcase
  end

  AST_FLAG_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mflag_q) |-> $past(hit)); // R3
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q == M_ONE && !wr_ctrl) |=> !en_q); // R4
  AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q != M_CONT) |=> (cnt_q == '0)); // R5
  AST_TGL_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tgl_q) |-> $past(hit && mode_q == M_TGL)); // R5
  AST_CONT_KEEPS_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode_q == M_CONT && !clr_req) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R6
  AST_WAKE_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wflag_q) |-> $past(wake)); // R8
  AST_CMP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmp && mode_q != M_CONT) |=> (cnt_q == '0 && pcnt_q == '0)); // R9
  AST_CLEAR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && en_q) |=> (!en_q && cnt_q == '0)); // R10
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !dbgrun_q && !reg_wr) |=> $stable(cnt_q)); // R12

endmodule

// File: tb/sim_pscmp_timer.sv
`timescale 1ns/1ps
module sim_pscmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dbg_halt = 1'b0;
  logic        irq, wake, tgl_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pscmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_halt(dbg_halt),
    .irq(irq), .wake(wake), .tgl_out(tgl_out));

  function automatic logic [31:0] ctl(int psc, int mode, bit en, bit ien,
                                      bit wen, bit view, bit dbgrun, bit clr);
    logic [31:0] w;
    w = '0;
    w[7:0] = psc[7:0];
    w[9:8] = mode[1:0];
    w[10] = en; w[11] = ien; w[12] = wen;
    w[13] = view; w[14] = dbgrun; w[15] = clr;
    return w;
  endfunction

  function automatic int exp_view(int k, int p, int c);
    if (k < 1) return 0;
    return ((k - 1) / (p + 1)) % c;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin
    logic [31:0] v;
    int s;
    s = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk("R2 reset register", v, 0);
    end
    chk("R2 reset outputs", {29'd0, irq, wake, tgl_out}, 0);

    for (int it = 0; it < 20; it++) begin
      int p, c, k;
      p = $urandom_range(0, 5);
      c = $urandom_range(2, 20);
      k = $urandom_range(1, 2 * c * (p + 1));
      wr(2'd0, ctl(0, 1, 0, 0, 0, 0, 0, 1));
      wr(2'd2, 32'd3);
      wr(2'd1, c);
      wr(2'd0, ctl(p, 1, 1, 0, 0, 1, 0, 0));
      idle(k);
      rd(2'd3, v); chk("R1 prescaled count", v, exp_view(k, p, c));
      rd(2'd2, v); chk("R3 match flag timing", v[0], (k >= c * (p + 1)) ? 1 : 0);
    end

    wr(2'd0, ctl(0, 0, 0, 0, 0, 0, 0, 1));
    wr(2'd2, 32'd3);
    wr(2'd1, 5);
    wr(2'd0, ctl(0, 0, 1, 1, 0, 1, 0, 0));
    idle(3);
    rd(2'd0, v); chk("R11 active while running", v[16], 1);
    idle(5);
    rd(2'd0, v); chk("R4 one-shot clears enable", v[10], 0);
    chk("R11 inactive after one-shot", v[16], 0);
    rd(2'd3, v); chk("R4 one-shot counter zero", v, 0);
    rd(2'd2, v); chk("R3 flag after one-shot", v[0], 1);
    chk("R7 irq with enable", irq, 1);
    wr(2'd2, 32'd0);
    rd(2'd2, v); chk("R3 write 0 ignored", v[0], 1);
    wr(2'd2, 32'd1);
    rd(2'd2, v); chk("R3 write 1 clears", v[0], 0);
    chk("R7 irq drops with flag", irq, 0);

    wr(2'd1, 4);
    wr(2'd0, ctl(0, 0, 1, 0, 0, 1, 0, 0));
    idle(6);
    rd(2'd2, v); chk("R7 flag set, irq disabled", v[0], 1);
    chk("R7 irq masked", irq, 0);
    wr(2'd2, 32'd3);

    wr(2'd1, 3);
    wr(2'd0, ctl(0, 0, 1, 1, 1, 1, 0, 0));
    idle(3);
    chk("R8 wake level", wake, 1);
    rd(2'd2, v); chk("R8 wake flag not yet", v[1], 0);
    idle(1);
    rd(2'd2, v); chk("R8 wake flag set next cycle", v[1], 1);
    wr(2'd0, ctl(0, 0, 0, 0, 1, 1, 0, 0));
    chk("R8 wake drops without irq enable", wake, 0);
    wr(2'd2, 32'd2);
    rd(2'd2, v); chk("R8 wake flag cleared", v[1:0], 2'b01);
    wr(2'd2, 32'd3);

    wr(2'd0, ctl(0, 2, 0, 0, 0, 0, 0, 1));
    wr(2'd1, 3);
    wr(2'd0, ctl(1, 2, 1, 0, 0, 1, 0, 0));
    idle(7);
    chk("R5 toggle after first match", tgl_out, 1);
    idle(5);
    chk("R5 toggle after second match", tgl_out, 0);
    rd(2'd3, v); chk("R5 periodic restart count", v, 2);

    wr(2'd0, ctl(0, 3, 0, 0, 0, 0, 0, 1));
    wr(2'd2, 32'd3);
    wr(2'd1, 4);
    wr(2'd0, ctl(0, 3, 1, 0, 0, 1, 0, 0));
    idle(10);
    rd(2'd3, v); chk("R6 continuous passes match", v, 9);
    rd(2'd2, v); chk("R6 continuous flag", v[0], 1);
    wr(2'd1, 100);
    idle(2);
    rd(2'd3, v); chk("R9 continuous compare write no restart", v, 12);

    wr(2'd0, ctl(0, 1, 0, 0, 0, 0, 0, 1));
    wr(2'd1, 1000);
    wr(2'd0, ctl(0, 1, 1, 0, 0, 1, 0, 0));
    idle(20);
    wr(2'd1, 500);
    idle(3);
    rd(2'd3, v); chk("R9 compare write restarts", v, 2);

    wr(2'd0, ctl(0, 1, 1, 0, 0, 1, 0, 1));
    idle(2);
    rd(2'd0, v); chk("R10 clear forces enable off", v[10], 0);
    chk("R10 clear bit reads 0", v[15], 0);
    rd(2'd3, v); chk("R10 clear zeroes counter", v, 0);
    wr(2'd0, ctl(0, 1, 1, 0, 0, 1, 0, 1));
    idle(4);
    rd(2'd3, v); chk("R10 clear with start while idle", v, 3);

    dbg_halt = 1'b1;
    idle(6);
    rd(2'd3, v); chk("R12 halt freezes count", v, 4);
    wr(2'd0, ctl(0, 1, 1, 0, 0, 1, 1, 0));
    idle(5);
    rd(2'd3, v); chk("R12 halt ignored", v, 8);
    dbg_halt = 1'b0;

    wr(2'd0, ctl(0, 1, 1, 0, 0, 0, 1, 0));
    idle(10);
    rd(2'd3, v); chk("R13 snapshot holds", v, 9);
    wr(2'd0, ctl(0, 1, 1, 0, 0, 1, 1, 0));
    idle(1);
    rd(2'd3, v); chk("R13 snapshot resumes", v, 21);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule